// File: doc/BRIEF.md
# Shared Display-Memory Bus Arbiter

This block decides who drives a display-memory bus that a CPU and a DMA engine share. The CPU side is an asynchronous strobe-and-acknowledge bus: the CPU lowers an address strobe and waits for an active-low acknowledge. The DMA side does not handshake. It lowers a request line ahead of the slot it wants, and it supplies its own address. The block steers the memory address lines to whichever side owns the current slot. It enables the CPU bus drivers only while the CPU holds a grant.

The block runs on the CPU clock. From that clock it derives a shared-bus clock at half the rate, so one bus slot is two CPU clocks long. Ownership of the display bus changes only on slot boundaries. A CPU access to display memory or register space is therefore acknowledged only when a slot opens for it. This gives a fixed phase relation between the CPU cycle and the slower bus clock, and it applies even when the DMA engine is idle.

CPU accesses to the private region (ROM and peripherals) never touch the display bus. They are acknowledged at once, and the DMA engine can use the display bus at the same moment.

Top module: `sba_arbiter`

## Requirements
- R1: While rst_n is low, after the first clock edge, cpu_dtack_n is 1, cpu_drv_en is 0, owner_dma is 0 and cclk is 0.
- R2: After reset, cclk toggles on every clock edge. A slot boundary is a clock edge at which cclk was 0 just before the edge.
- R3: The top two bits of cpu_addr select the region. The value 2'b10 is the private region. The values 2'b00, 2'b01 and 2'b11 are shared (display memory or registers).
- R4: At a slot boundary where no CPU grant is being held, a low dma_req_n gives the bus to DMA (owner_dma=1). DMA keeps the bus until a slot boundary where dma_req_n is high.
- R5: A shared CPU access is granted (cpu_drv_en=1, cpu_dtack_n=0) only at a slot boundary, and only if dma_req_n is high at that boundary. While DMA owns the bus, a shared access stays unacknowledged.
- R6: Once granted, the CPU keeps the bus while cpu_as_n stays low, even if dma_req_n goes low.
- R7: After the clock edge at which cpu_as_n is seen high, cpu_dtack_n is 1 and cpu_drv_en is 0. Both change at that same edge.
- R8: A private access is acknowledged one clock edge after cpu_as_n is sampled low, whatever the DMA state. The private access does not change DMA ownership.
- R9: mem_addr equals dma_addr while owner_dma is 1, and equals cpu_addr otherwise.
- R10: cpu_drv_en and owner_dma are never 1 at the same time.
- R11: With no DMA request, a shared access that first asserts its strobe while cclk is 0 is acknowledged after 1 clock edge. If cclk is 1 at that point, it is acknowledged after 2 clock edges.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock; the shared-bus clock is derived from it |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_as_n | input | 1 | CPU address strobe, active low |
| cpu_addr | input | AW | CPU address; the top two bits select the region |
| dma_req_n | input | 1 | DMA bus request, active low, sampled at slot boundaries |
| dma_addr | input | AW | Address held in the DMA address register |
| cpu_dtack_n | output | 1 | Data acknowledge to the CPU, active low |
| cpu_drv_en | output | 1 | Enables the CPU bus drivers onto the display bus (CPU grant) |
| owner_dma | output | 1 | 1 while DMA owns the display bus |
| mem_addr | output | AW | Address driven onto the display-memory bus |
| cclk | output | 1 | Derived shared-bus clock, half the clk rate |

## Verification
The assertions assume that cpu_addr stays stable while cpu_as_n is low. They also assume that every input changes only between clock edges, and that a strobe is released only after it has been acknowledged. The bench drives every input on the falling edge and never changes the address in the middle of an access. It raises the strobe only after it has seen the acknowledge. The sweep covers both starting phases, all four region codes, DMA requests that arrive before or after the CPU strobe, and several strobe hold lengths. A cycle model built from the requirements checks every output on every cycle.

// File: rtl/sba_pkg.sv
// Shared types for the display-bus arbiter.
package sba_pkg;
    typedef enum logic [1:0] {
        OWN_IDLE = 2'd0,
        OWN_CPU  = 2'd1,
        OWN_DMA  = 2'd2
    } own_t;
endpackage

// File: rtl/sba_slot_clock.sv
// Derives the half-rate shared-bus clock from the CPU clock.
// Assumes one slot equals two CPU clocks; boundary = edge where phase is low.
module sba_slot_clock (
    input  logic clk,
    input  logic rst_n,
    output logic phase,
    output logic slot_edge
);
    // Toggle the phase once per CPU clock.
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= 1'b0;
        else        phase <= ~phase;
    end

    // The next edge opens a new slot when the phase is currently low.
    always_comb slot_edge = ~phase;
endmodule

// File: rtl/sba_region_decode.sv
// Classifies the CPU address and acknowledges private-region accesses.
// Assumes the address is stable while the strobe is low.
module sba_region_decode #(
    parameter int AW = 24,
    parameter int RW = 2,
    parameter logic [RW-1:0] PRIV_CODE = 2'b10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          as_n,
    input  logic [AW-1:0] addr,
    output logic          shared_req,
    output logic          priv_ack
);
    localparam int TOP = AW - 1;
    localparam int BOT = AW - RW;

    logic is_priv;

    // Decode the region from the top address bits.
    always_comb begin
        is_priv    = (addr[TOP:BOT] == PRIV_CODE);
        shared_req = ~as_n & ~is_priv;
    end

    // Private accesses are acknowledged one edge after the strobe is seen.
    always_ff @(posedge clk) begin
        if (!rst_n) priv_ack <= 1'b0;
        else        priv_ack <= ~as_n & is_priv;
    end
endmodule

// File: rtl/sba_owner_fsm.sv
// Ownership state of the display bus.
// DMA wins at a slot boundary unless a granted CPU cycle is still running;
// a CPU grant ends on any edge once the strobe is high.
module sba_owner_fsm
    import sba_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic slot_edge,
    input  logic as_n,
    input  logic shared_req,
    input  logic dma_req_n,
    output own_t owner
);
    own_t owner_nxt;
    logic cpu_keep;

    // Decide the next owner.
    always_comb begin
        cpu_keep  = (owner == OWN_CPU) && !as_n;
        owner_nxt = owner;
        if (slot_edge) begin
            if (cpu_keep)        owner_nxt = OWN_CPU;
            else if (!dma_req_n) owner_nxt = OWN_DMA;
            else if (shared_req) owner_nxt = OWN_CPU;
            else                 owner_nxt = OWN_IDLE;
        end else if (owner == OWN_CPU && as_n) begin
            owner_nxt = OWN_IDLE;
        end
    end

    // Register the owner.
    always_ff @(posedge clk) begin
        if (!rst_n) owner <= OWN_IDLE;
        else        owner <= owner_nxt;
    end
endmodule

// File: rtl/sba_arbiter.sv
// Top of the display-bus arbiter: derives the slot clock, decodes the region,
// tracks the owner and steers the memory address and the CPU acknowledge.
// Assumes inputs change only between clock edges.
module sba_arbiter
    import sba_pkg::*;
#(
    parameter int AW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpu_as_n,
    input  logic [AW-1:0] cpu_addr,
    input  logic          dma_req_n,
    input  logic [AW-1:0] dma_addr,
    output logic          cpu_dtack_n,
    output logic          cpu_drv_en,
    output logic          owner_dma,
    output logic [AW-1:0] mem_addr,
    output logic          cclk
);
    logic slot_edge, shared_req, priv_ack;
    own_t owner;

    sba_slot_clock u_slot (
        .clk(clk), .rst_n(rst_n), .phase(cclk), .slot_edge(slot_edge)
    );

    sba_region_decode #(.AW(AW)) u_dec (
        .clk(clk), .rst_n(rst_n), .as_n(cpu_as_n), .addr(cpu_addr),
        .shared_req(shared_req), .priv_ack(priv_ack)
    );

    sba_owner_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .slot_edge(slot_edge), .as_n(cpu_as_n),
        .shared_req(shared_req), .dma_req_n(dma_req_n), .owner(owner)
    );

    // Drive grants, acknowledge and the address mux from the owner.
    always_comb begin
        cpu_drv_en  = (owner == OWN_CPU);
        owner_dma   = (owner == OWN_DMA);
        cpu_dtack_n = ~(cpu_drv_en | priv_ack);
        mem_addr    = owner_dma ? dma_addr : cpu_addr;
    end
endmodule

// File: rtl/sba_arbiter_chk.sv
// Property checker for sba_arbiter, bound to every instance.
module sba_arbiter_chk #(
    parameter int AW = 24
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cpu_as_n,
    input logic [AW-1:0] cpu_addr,
    input logic          dma_req_n,
    input logic [AW-1:0] dma_addr,
    input logic          cpu_dtack_n,
    input logic          cpu_drv_en,
    input logic          owner_dma,
    input logic [AW-1:0] mem_addr,
    input logic          cclk
);
    logic priv;
    always_comb priv = (cpu_addr[AW-1:AW-2] == 2'b10);

    AST_CCLK_RISE: assert property (@(posedge clk) disable iff (!rst_n) !cclk |=> cclk); // R2
    AST_CCLK_FALL: assert property (@(posedge clk) disable iff (!rst_n) cclk |=> !cclk); // R2
    AST_GRANT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n) !(cpu_drv_en && owner_dma)); // R10
    AST_CPU_GRANT_ON_SLOT: assert property (@(posedge clk) disable iff (!rst_n) $rose(cpu_drv_en) |-> cclk); // R5
    AST_DMA_BLOCKS_SHARED: assert property (@(posedge clk) disable iff (!rst_n) (owner_dma && !cpu_as_n && !priv) |-> cpu_dtack_n); // R5
    AST_NO_PREEMPT: assert property (@(posedge clk) disable iff (!rst_n) (cpu_drv_en && !cpu_as_n) |=> cpu_drv_en); // R6
    AST_RELEASE: assert property (@(posedge clk) disable iff (!rst_n) cpu_as_n |=> (cpu_dtack_n && !cpu_drv_en)); // R7
    AST_PRIV_ACK: assert property (@(posedge clk) disable iff (!rst_n) (!cpu_as_n && priv) |=> !cpu_dtack_n); // R8
    AST_DMA_ADDR: assert property (@(posedge clk) disable iff (!rst_n) owner_dma |-> (mem_addr == dma_addr)); // R9
endmodule

bind sba_arbiter sba_arbiter_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .cpu_as_n(cpu_as_n), .cpu_addr(cpu_addr),
    .dma_req_n(dma_req_n), .dma_addr(dma_addr), .cpu_dtack_n(cpu_dtack_n),
    .cpu_drv_en(cpu_drv_en), .owner_dma(owner_dma), .mem_addr(mem_addr),
    .cclk(cclk)
);

// File: tb/sim_sba_arbiter.sv
// Bench: sweeps phase, region, DMA timing and hold length; a cycle model
// derived from the requirements checks every output on every cycle.
module sim_sba_arbiter;
    localparam int AW = 24;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cpu_as_n = 1'b1;
    logic [AW-1:0] cpu_addr = '0;
    logic          dma_req_n = 1'b1;
    logic [AW-1:0] dma_addr = '0;
    logic          cpu_dtack_n, cpu_drv_en, owner_dma, cclk;
    logic [AW-1:0] mem_addr;

    int n_run = 0;
    int n_fail = 0;
    int m_own = 0;     // 0 idle, 1 cpu, 2 dma
    logic m_ph = 1'b0;
    logic m_priv = 1'b0;
    logic [19:0] seq = 20'h1;

    sba_arbiter #(.AW(AW)) u0 (
        .clk(clk), .rst_n(rst_n), .cpu_as_n(cpu_as_n), .cpu_addr(cpu_addr),
        .dma_req_n(dma_req_n), .dma_addr(dma_addr), .cpu_dtack_n(cpu_dtack_n),
        .cpu_drv_en(cpu_drv_en), .owner_dma(owner_dma), .mem_addr(mem_addr),
        .cclk(cclk)
    );

    always #10 clk = ~clk;

    function automatic logic is_priv(input logic [AW-1:0] a);
        return a[AW-1:AW-2] == 2'b10;
    endfunction

    // Reference model of the requirements, advanced on each rising edge.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph <= 1'b0; m_own <= 0; m_priv <= 1'b0;
        end else begin
            m_ph   <= ~m_ph;
            m_priv <= !cpu_as_n && is_priv(cpu_addr);
            if (!m_ph) begin
                if (m_own == 1 && !cpu_as_n)                    m_own <= 1;
                else if (!dma_req_n)                            m_own <= 2;
                else if (!cpu_as_n && !is_priv(cpu_addr))       m_own <= 1;
                else                                            m_own <= 0;
            end else if (m_own == 1 && cpu_as_n) begin
                m_own <= 0;
            end
        end
    end

    task automatic chk(input string tag, input logic [AW-1:0] act, input logic [AW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cycle_check();
        chk("R2 cclk", AW'(cclk), AW'(m_ph));
        chk("R4 owner_dma", AW'(owner_dma), AW'(m_own == 2));
        chk("R5 cpu_drv_en", AW'(cpu_drv_en), AW'(m_own == 1));
        chk("R7 cpu_dtack_n", AW'(cpu_dtack_n), AW'(!(m_own == 1 || m_priv)));
        chk("R9 mem_addr", mem_addr, (m_own == 2) ? dma_addr : cpu_addr);
        chk("R10 exclusive", AW'(cpu_drv_en && owner_dma), '0);
    endtask

    task automatic step();
        @(negedge clk);
        cycle_check();
    endtask

    // One access: start phase sp, region rg, DMA mode md, hold hd edges.
    task automatic run_case(input int sp, input int rg, input int md, input int hd);
        int lat = -1;
        int exp_lat;
        logic shared = (rg != 2);
        while (m_ph != sp[0]) step();
        exp_lat = !shared ? 1 : (md == 0 ? (sp == 0 ? 1 : 2) : -1);
        seq = seq * 20'd5 + 20'd3;
        cpu_addr = {rg[1:0], 2'b01, seq};
        dma_addr = {2'b00, ~seq, 2'b10};
        cpu_as_n = 1'b0;
        for (int t = 0; t < 40; t++) begin
            case (md)
                1:       dma_req_n = !(t < 4);
                2:       dma_req_n = !(t >= 1 && t < 5);
                default: dma_req_n = 1'b1;
            endcase
            step();
            if (!cpu_dtack_n && lat < 0) lat = t + 1;
            if (lat >= 0 && t + 1 >= lat + hd) break;
        end
        chk("R5 access acknowledged", AW'(lat >= 0), AW'(1));
        if (exp_lat > 0) begin
            if (shared) chk("R11 ack latency", AW'(lat), AW'(exp_lat));
            else        chk("R8 R3 private ack latency", AW'(lat), AW'(exp_lat));
        end
        cpu_as_n = 1'b1;
        dma_req_n = 1'b1;
        repeat (3) step();
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 dtack", AW'(cpu_dtack_n), AW'(1));
        chk("R1 drv_en", AW'(cpu_drv_en), '0);
        chk("R1 owner", AW'(owner_dma), '0);
        chk("R1 cclk", AW'(cclk), '0);
        rst_n = 1'b1;
        repeat (2) step();
        for (int sp = 0; sp < 2; sp++)
            for (int rg = 0; rg < 4; rg++)
                for (int md = 0; md < 3; md++)
                    for (int hd = 1; hd < 4; hd++)
                        run_case(sp, rg, md, hd);
        // R6: DMA request arriving after a CPU grant does not preempt it.
        while (m_ph != 1'b0) step();
        cpu_addr = {2'b00, 22'h155};
        cpu_as_n = 1'b0;
        step();
        dma_req_n = 1'b0;
        repeat (4) step();
        chk("R6 grant held under DMA request", AW'(cpu_drv_en), AW'(1));
        cpu_as_n = 1'b1;
        step();
        chk("R7 release dtack", AW'(cpu_dtack_n), AW'(1));
        repeat (3) step();
        chk("R4 DMA takes bus", AW'(owner_dma), AW'(1));
        dma_req_n = 1'b1;
        repeat (3) step();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule